// File: doc/BRIEF.md
# Multi-Basis Binary Convolution Accumulator

This block produces one output activation of a binary convolution whose weights are approximated by M binary weight bases and whose activations are approximated by N binary activation bases. Each basis pair (m, n) contributes a bit-count that is scaled by the product of a learned weight scale alpha[m] and a learned activation scale beta[n]. The scaled contributions are summed into a fixed-point result. For one channel, the bit-count is the number of positions where a K×K binary weight window and a K×K binary activation window agree, which is the popcount of their XNOR.

An upstream window engine streams one channel per beat on a valid/ready interface. It raises a last-channel flag on the final channel of each basis pair. The block adds the per-channel counts until the flag arrives. It then hands the pair's total count to a two-stage scaling pipeline. Stage one forms alpha·beta. Stage two multiplies that product by the count, rescales it and adds it into a saturating running total. The input stalls while this pipeline holds a pair. After the last pair it presents the result with a single-cycle valid. The scales sit in two small write-only register files that are loaded before a computation starts.

Top module: `bconv_acc`

## Requirements
- R1: The count contributed by one beat is the number of the K·K bit positions (K = 3 by default, a 9-bit window) at which `in_wgt` and `in_act` hold equal values.
- R2: Beat counts are added across all channel beats of one basis pair, up to and including the beat with `in_last` = 1, and only this summed count is scaled.
- R3: Basis pairs are taken in the order (0,0), (0,1), …, (0,N-1), (1,0), …, (M-1,N-1), with the n index changing fastest. The k-th pair is scaled by alpha[m]·beta[n], and one output is produced every M·N pairs.
- R4: Scales are signed two's-complement with SCALE_W = 8 bits, of which SCALE_FRAC = 4 are fractional. A pair adds floor(alpha·beta·count / 2^SCALE_FRAC), in raw units, to a total that has SCALE_FRAC fractional bits.
- R5: After each pair the running total is clamped to the signed OUT_W-bit range (default 16 bits: −32768 to 32767). The clamp is applied at each addition, not only at the end.
- R6: After a beat with `in_last` = 1 is accepted, `in_ready` is low for exactly the next two cycles and then high again. A beat offered while `in_ready` is low is not taken and does not change the result. `in_ready` stays high after a beat accepted with `in_last` = 0.
- R7: `out_valid` pulses high for one cycle, two cycles after the edge that accepts the final pair's last beat. `out_data` changes only in that cycle and holds its value until the next result.
- R8: The running total restarts with pair (0,0), so a result never includes contributions from an earlier output.
- R9: Reset (synchronous, active high) sets `out_valid` = 0, `out_data` = 0 and `in_ready` = 1. It clears the partial channel count and returns the pair sequence to (0,0).
- R10: With `cfg_we` = 1 at a clock edge, `cfg_data` is written to the alpha entry `cfg_idx` when `cfg_sel` = 0, or to the beta entry `cfg_idx` when `cfg_sel` = 1. The written values are used by every pair scaled afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Scale write enable |
| cfg_sel | input | 1 | 0 selects the alpha file, 1 selects the beta file |
| cfg_idx | input | CFG_IDX_W (1) | Scale entry index |
| cfg_data | input | SCALE_W (8) | Signed scale value, SCALE_FRAC fractional bits |
| in_valid | input | 1 | Channel beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_wgt | input | K·K (9) | Binary weight window |
| in_act | input | K·K (9) | Binary activation window |
| in_last | input | 1 | Beat is the last channel of the current basis pair |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W (16) | Signed accumulated activation, SCALE_FRAC fractional bits |

## Verification
The bench drives alternating positive and negative scales through a series of pairs that overflow part-way. A design that clamps only at the end would return a value near zero instead of one that recovers from the clamped top. It also drives windows that are full inverses and full matches, which expose a popcount of XOR instead of XNOR or an off-by-one count width. During the two stall cycles it offers junk last-channel beats. A design that accepts these would shift the pair sequence and return a wrong total. A reset in the middle of a partial pair checks that stale channel counts and pair indices do not leak into the next result.

// File: rtl/bconv_pkg.sv
package bconv_pkg;
  // which scale file a configuration write targets
  typedef enum logic {
    SCL_ALPHA = 1'b0,
    SCL_BETA  = 1'b1
  } scale_sel_e;

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/bconv_popcount.sv
module bconv_popcount #(
  parameter int WIN  = 9,
  parameter int PC_W = $clog2(WIN + 1)
) (
  input  logic [WIN-1:0]  wgt,
  input  logic [WIN-1:0]  act,
  output logic [PC_W-1:0] ones
);
  logic [WIN-1:0] agree;

  for (genvar g = 0; g < WIN; g++) begin : g_xnor
    assign agree[g] = ~(wgt[g] ^ act[g]);
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN; i++) ones = ones + PC_W'(agree[i]);
  end
endmodule

// File: rtl/bconv_scale_rf.sv
module bconv_scale_rf #(
  parameter int IDX_W   = 1,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [SCALE_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [SCALE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SCALE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bconv_scale_mac.sv
module bconv_scale_mac #(
  parameter int CNT_W      = 8,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 4,
  parameter int OUT_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               first,
  input  logic               final_pair,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SCALE_W-1:0] alpha,
  input  logic [SCALE_W-1:0] beta,
  output logic               busy,
  output logic               res_valid,
  output logic [OUT_W-1:0]   res_data
);
  localparam int AB_W   = 2 * SCALE_W;
  localparam int PROD_W = AB_W + CNT_W + 1;
  localparam int SUM_W  = ((PROD_W > OUT_W) ? PROD_W : OUT_W) + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = (SUM_W'(1) <<< (OUT_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -(SUM_W'(1) <<< (OUT_W - 1));

  logic                     s2_v, s2_first, s2_final;
  logic signed [AB_W-1:0]   s2_ab;
  logic [CNT_W-1:0]         s2_cnt;
  logic signed [OUT_W-1:0]  total;

  logic signed [PROD_W-1:0] prod, term;
  logic signed [SUM_W-1:0]  base_ext, term_ext, sum;
  logic signed [OUT_W-1:0]  sum_sat;

  always_comb begin
    prod     = PROD_W'(s2_ab) * PROD_W'($signed({1'b0, s2_cnt}));
    term     = prod >>> SCALE_FRAC;
    term_ext = SUM_W'(term);
    base_ext = s2_first ? '0 : SUM_W'(total);
    sum      = base_ext + term_ext;
    if (sum > SAT_HI)      sum_sat = SAT_HI[OUT_W-1:0];
    else if (sum < SAT_LO) sum_sat = SAT_LO[OUT_W-1:0];
    else                   sum_sat = sum[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v      <= 1'b0;
      s2_first  <= 1'b0;
      s2_final  <= 1'b0;
      s2_ab     <= '0;
      s2_cnt    <= '0;
      total     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      s2_v      <= start;
      res_valid <= 1'b0;
      if (start) begin
        s2_ab    <= AB_W'($signed(alpha)) * AB_W'($signed(beta));
        s2_cnt   <= cnt;
        s2_first <= first;
        s2_final <= final_pair;
      end
      if (s2_v) begin
        total <= sum_sat;
        if (s2_final) begin
          res_valid <= 1'b1;
          res_data  <= sum_sat;
        end
      end
    end
  end

  assign busy = s2_v;
endmodule

// File: rtl/bconv_acc.sv
module bconv_acc
  import bconv_pkg::*;
#(
  parameter int K          = 3,
  parameter int CI_MAX     = 16,
  parameter int M_BASES    = 2,
  parameter int N_BASES    = 2,
  parameter int SCALE_W    = 8,
  parameter int SCALE_FRAC = 4,
  parameter int OUT_W      = 16,
  localparam int WIN       = K * K,
  localparam int PC_W      = $clog2(WIN + 1),
  localparam int CNT_W     = $clog2(WIN * CI_MAX + 1),
  localparam int A_IDX_W   = idx_width(M_BASES),
  localparam int B_IDX_W   = idx_width(N_BASES),
  localparam int CFG_IDX_W = (A_IDX_W > B_IDX_W) ? A_IDX_W : B_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [SCALE_W-1:0]   cfg_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [WIN-1:0]       in_wgt,
  input  logic [WIN-1:0]       in_act,
  input  logic                 in_last,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_data
);
  logic [PC_W-1:0]    beat_ones;
  logic [CNT_W-1:0]   chan_acc, beat_sum;
  logic [A_IDX_W-1:0] m_idx, s1_m;
  logic [B_IDX_W-1:0] n_idx, s1_n;
  logic [CNT_W-1:0]   s1_cnt;
  logic               s1_v, s1_first, s1_final;
  logic               mac_busy, accept, pair_done;
  logic [SCALE_W-1:0] alpha_rd, beta_rd;
  logic               m_end, n_end;

  bconv_popcount #(.WIN(WIN), .PC_W(PC_W)) u_pop (
    .wgt  (in_wgt),
    .act  (in_act),
    .ones (beat_ones)
  );

  bconv_scale_rf #(.IDX_W(A_IDX_W), .SCALE_W(SCALE_W)) u_alpha (
    .clk   (clk),
    .we    (cfg_we && (scale_sel_e'(cfg_sel) == SCL_ALPHA)),
    .waddr (cfg_idx[A_IDX_W-1:0]),
    .wdata (cfg_data),
    .raddr (s1_m),
    .rdata (alpha_rd)
  );

  bconv_scale_rf #(.IDX_W(B_IDX_W), .SCALE_W(SCALE_W)) u_beta (
    .clk   (clk),
    .we    (cfg_we && (scale_sel_e'(cfg_sel) == SCL_BETA)),
    .waddr (cfg_idx[B_IDX_W-1:0]),
    .wdata (cfg_data),
    .raddr (s1_n),
    .rdata (beta_rd)
  );

  assign in_ready  = !s1_v && !mac_busy;
  assign accept    = in_valid && in_ready;
  assign pair_done = accept && in_last;
  assign beat_sum  = chan_acc + CNT_W'(beat_ones);
  assign m_end     = (m_idx == A_IDX_W'(M_BASES - 1));
  assign n_end     = (n_idx == B_IDX_W'(N_BASES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_acc <= '0;
      m_idx    <= '0;
      n_idx    <= '0;
      s1_v     <= 1'b0;
      s1_m     <= '0;
      s1_n     <= '0;
      s1_cnt   <= '0;
      s1_first <= 1'b0;
      s1_final <= 1'b0;
    end else begin
      s1_v <= pair_done;
      if (accept) begin
        if (in_last) begin
          chan_acc <= '0;
          s1_cnt   <= beat_sum;
          s1_m     <= m_idx;
          s1_n     <= n_idx;
          s1_first <= (m_idx == '0) && (n_idx == '0);
          s1_final <= m_end && n_end;
          if (n_end) begin
            n_idx <= '0;
            m_idx <= m_end ? '0 : m_idx + A_IDX_W'(1);
          end else begin
            n_idx <= n_idx + B_IDX_W'(1);
          end
        end else begin
          chan_acc <= beat_sum;
        end
      end
    end
  end

  bconv_scale_mac #(
    .CNT_W(CNT_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .OUT_W(OUT_W)
  ) u_mac (
    .clk        (clk),
    .rst        (rst),
    .start      (s1_v),
    .first      (s1_first),
    .final_pair (s1_final),
    .cnt        (s1_cnt),
    .alpha      (alpha_rd),
    .beta       (beta_rd),
    .busy       (mac_busy),
    .res_valid  (out_valid),
    .res_data   (out_data)
  );
endmodule

// File: rtl/bconv_acc_chk.sv
module bconv_acc_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  // R6
  stall_first_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R6
  stall_second_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready && in_last, 2) && !$past(rst, 1) && !$past(rst, 2)) |-> !in_ready);

  // R6
  stream_open_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_last) |=> in_ready);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

bind bconv_acc bconv_acc_chk #(.OUT_W(OUT_W)) u_bconv_acc_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/test_bconv_acc.sv
module test_bconv_acc;
  localparam int CLK_P = 10;
  localparam int M = 2, N = 2, FRAC = 4, OUT_W = 16;
  localparam longint SAT_HI = 32767, SAT_LO = -32768;
  localparam int NVEC = 14;
  // {weight window, activation window, last-channel flag}
  localparam logic [18:0] VEC [NVEC] = '{
    {9'h1A5, 9'h0F3, 1'b0}, {9'h03C, 9'h13C, 1'b1},
    {9'h1FF, 9'h000, 1'b0}, {9'h155, 9'h155, 1'b0}, {9'h0AA, 9'h1F0, 1'b1},
    {9'h111, 9'h0EE, 1'b1},
    {9'h123, 9'h1C3, 1'b0}, {9'h0FF, 9'h0F0, 1'b1},
    {9'h000, 9'h000, 1'b1},
    {9'h1E1, 9'h03E, 1'b1},
    {9'h07F, 9'h1FC, 1'b0}, {9'h101, 9'h011, 1'b1},
    {9'h0C3, 9'h0C3, 1'b0}, {9'h18E, 9'h071, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [0:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [8:0] in_wgt = '0, in_act = '0;
  logic out_valid;
  logic [OUT_W-1:0] out_data;

  int checks = 0, errors = 0;
  longint ma [M], mb [N];
  longint mcnt = 0, mtotal = 0, last_out = 0;
  int mpair = 0;
  bit junk_stall = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bconv_acc i_bconv_acc (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready), .in_wgt(in_wgt),
    .in_act(in_act), .in_last(in_last), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R10: cfg_sel 0 = alpha file, 1 = beta file
  task automatic set_scale(input bit is_beta, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = is_beta; cfg_idx = 1'(idx); cfg_data = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_beta) mb[idx] = val; else ma[idx] = val;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    mcnt = 0; mpair = 0; mtotal = 0; last_out = 0;
  endtask

  // drive one channel beat at a negedge and follow the model through stall and output
  task automatic do_beat(input logic [8:0] w, input logic [8:0] a, input logic last);
    longint term, s;
    in_valid = 1'b1; in_wgt = w; in_act = a; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    mcnt += $countones(~(w ^ a));                       // R1, R2
    if (!last) begin
      check(in_ready == 1'b1, "R6 ready after inner beat", longint'(in_ready), 1);
      return;
    end
    term = (ma[mpair / N] * mb[mpair % N] * mcnt) >>> FRAC;   // R3, R4
    s = ((mpair == 0) ? 0 : mtotal) + term;                    // R8
    mtotal = (s > SAT_HI) ? SAT_HI : (s < SAT_LO) ? SAT_LO : s; // R5
    check(in_ready == 1'b0, "R6 stall cycle 1", longint'(in_ready), 0);
    if (junk_stall) begin
      in_valid = 1'b1; in_wgt = 9'h000; in_act = 9'h000; in_last = 1'b1;
    end
    @(negedge clk);
    check(in_ready == 1'b0, "R6 stall cycle 2", longint'(in_ready), 0);
    check(out_valid == 1'b0, "R7 no early strobe", longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b1, "R6 ready after stall", longint'(in_ready), 1);
    if (mpair == M * N - 1) begin
      check(out_valid == 1'b1, "R7 result strobe", longint'(out_valid), 1);
      check(longint'($signed(out_data)) == mtotal, "R3 R4 R5 R8 result",
            longint'($signed(out_data)), mtotal);
      last_out = mtotal;
      @(negedge clk);
      check(out_valid == 1'b0 && longint'($signed(out_data)) == last_out,
            "R7 pulse and hold", longint'(out_valid), 0);
      mpair = 0;
    end else begin
      check(out_valid == 1'b0, "R7 no strobe mid sequence", longint'(out_valid), 0);
      mpair++;
    end
    mcnt = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset out_valid", longint'(out_valid), 0);
    check(out_data == '0, "R9 reset out_data", longint'(out_data), 0);
    check(in_ready == 1'b1, "R9 reset in_ready", longint'(in_ready), 1);
    rst = 1'b0;

    // R10 load scales: alpha 1.5, -0.75; beta 2.25, 0.5
    set_scale(0, 0, 24); set_scale(0, 1, -12);
    set_scale(1, 0, 36); set_scale(1, 1, 8);

    // table walk: two full outputs, second one checks restart (R8)
    for (int i = 0; i < NVEC; i++) do_beat(VEC[i][18:10], VEC[i][9:1], VEC[i][0]);

    // R1 corner: inverted windows give zero counts, result 0
    for (int p = 0; p < M * N; p++) do_beat(9'h0F0, 9'h10F, 1'b1);

    // R1 corner: identical windows, full count
    for (int p = 0; p < M * N; p++) do_beat(9'h1B6, 9'h1B6, 1'b1);

    // R5 positive clamp
    set_scale(0, 0, 127); set_scale(0, 1, 127);
    set_scale(1, 0, 127); set_scale(1, 1, 127);
    for (int p = 0; p < M * N; p++) do_beat(9'h000, 9'h000, 1'b1);

    // R5 negative clamp
    set_scale(0, 0, -128); set_scale(0, 1, -128);
    for (int p = 0; p < M * N; p++) do_beat(9'h000, 9'h000, 1'b1);

    // R5 clamp per addition: +sat then large negatives pull back
    set_scale(0, 0, 127); set_scale(0, 1, -128);
    for (int p = 0; p < M * N; p++) begin
      do_beat(9'h000, 9'h000, 1'b0);
      do_beat(9'h000, 9'h000, 1'b0);
      do_beat(9'h000, 9'h000, 1'b1);
    end

    // R6 junk beats offered during stall must be ignored
    set_scale(0, 1, 20); set_scale(1, 1, -40);
    junk_stall = 1'b1;
    for (int i = 0; i < 8; i++) do_beat(VEC[i][18:10], VEC[i][9:1], VEC[i][0]);
    junk_stall = 1'b0;

    // R9 reset in the middle of a pair, then a clean sequence
    do_beat(9'h1FF, 9'h1FF, 1'b0);
    do_beat(9'h1FF, 9'h1FF, 1'b1);
    do_beat(9'h1FF, 9'h1FF, 1'b0);
    do_reset();
    check(in_ready == 1'b1 && out_valid == 1'b0, "R9 mid-run reset", longint'(in_ready), 1);
    for (int i = 0; i < 8; i++) do_beat(VEC[i][18:10], VEC[i][9:1], VEC[i][0]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule